// File: doc/BRIEF.md
# Edge-Event GPIO Controller

This block is a general-purpose pin controller with 32 pins, reached over a plain word-wide register bus. Software picks each pin's direction, writes the value that output pins drive, and reads back a level register. Output pins show the stored value. Input pins show the level that was sampled off the pad. Each input pin also feeds an edge detector. A pin-level control bit selects whether that detector reacts to any level change or to falling edges only. A detected edge latches a sticky event bit. One level interrupt line goes high whenever an event bit is set and its mask bit is also set. Software clears event bits by writing ones to them.

The block has six registers, each one full word wide: direction, open-drain (stored and read back, with no effect on the pins), level, event, mask and sense-control. They sit at word offsets inside a 4 KB window. Pin n maps to register bit 31−n, so pin 0 is the most significant bit. Only accesses with all byte lanes enabled take effect. Input pads pass through a two-stage synchroniser. Edges are found by comparing the synchronised level with a copy of it delayed by one cycle.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, all six registers read zero, every `pin_oe` bit is 0, every `pin_out` bit is 0 and `irq` is 0.
- R2: The registers sit at these offsets: 0x000 direction, 0x004 open-drain, 0x008 level, 0x00C event, 0x010 mask, 0x014 sense. Direction, open-drain, mask and sense read back the last full-word value written to them.
- R3: An access with `bus_be` other than 4'b1111 has no effect. Such a write leaves every register unchanged, and such a read returns zero.
- R4: A read from any other offset returns zero. A write to any other offset changes no register.
- R5: Pin n uses register bit 31−n. A direction bit of 1 sets `pin_oe[n]` and drives `pin_out[n]` from level bit 31−n. A direction bit of 0 makes pin n an input, with `pin_oe[n]` and `pin_out[n]` both 0.
- R6: For an input pin, the level bit shows the pad level no later than 3 cycles after the pad changes. A write to the level register changes only the bits of output pins.
- R7: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a pin's sense bit is 0, both rising and falling edges on that input pin set its event bit.
- R9: When a pin's sense bit is 1, only a falling edge on that input pin sets its event bit. A rising edge does not.
- R10: `irq` is 1 exactly when some bit is set in both the event register and the mask register. It follows each register write on the next cycle.
- R11: If an edge sets an event bit in the same cycle that software writes 1 to clear that bit, the bit ends up set.
- R12: A level change on the pad of an output pin sets no event bit and does not change that pin's level bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| bus_addr | input | 12 | Byte offset inside the register window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_be | input | 4 | Byte-lane enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no valid read is in progress |
| pin_in | input | 32 | Pad levels, asynchronous, indexed by pin number |
| pin_out | output | 32 | Value driven on output pins, indexed by pin number |
| pin_oe | output | 32 | Output enable for each pin, indexed by pin number |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions rely on three things: the bus never raises read and write together, reset is released in step with the clock, and every pad is low while reset is active, so that the synchroniser's reset value of zero matches the pads. The stimulus drives bus strobes one cycle at a time, holds all pads low until after reset, and keeps each pad steady for at least four cycles after it changes. Each check therefore sees a settled synchroniser. The one exception is the collision case, in which a clear write is placed on the exact cycle an edge is recognised.

// File: rtl/gpio_ec_pkg.sv
package gpio_ec_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 12;
  localparam int LANES  = WORD_W / 8;

  localparam logic [OFS_W-1:0] OFS_DIRN  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_OPEN  = 12'h004;
  localparam logic [OFS_W-1:0] OFS_LEVEL = 12'h008;
  localparam logic [OFS_W-1:0] OFS_EVENT = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_MASK  = 12'h010;
  localparam logic [OFS_W-1:0] OFS_SENSE = 12'h014;

  localparam logic [LANES-1:0] LANES_ALL = '1;
endpackage

// File: rtl/gpio_ec_sync.sv
module gpio_ec_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_lvl,
  output logic [W-1:0] hist_lvl
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] hist_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] d;
    if (s == 0) begin : g_first
      assign d = async_in;
    end else begin : g_next
      assign d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= stage_q[STAGES-1];
  end

  assign sync_lvl = stage_q[STAGES-1];
  assign hist_lvl = hist_q;
endmodule

// File: rtl/gpio_ec_event.sv
module gpio_ec_event #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_lvl,
  input  logic [W-1:0] hist_lvl,
  input  logic [W-1:0] dirn,
  input  logic [W-1:0] sense,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] fell, changed, set_bits, clr_mask, evt_d;

  always_comb begin
    fell     = hist_lvl & ~sync_lvl;
    changed  = hist_lvl ^ sync_lvl;
    set_bits = ~dirn & ((sense & fell) | (~sense & changed));
    clr_mask = clr_en ? clr_bits : '0;
    evt_d    = (evt_q & ~clr_mask) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  // R11: a detected edge survives a same-cycle clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((evt_q & $past(set_bits)) == $past(set_bits)));

  // R7: bits written as 1 are cleared when no edge hits them
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((evt_q & $past(clr_bits & ~set_bits)) == '0));

  // R12: new events appear only on pins that were inputs
  a_r12_no_output_event: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & $past(dirn)) == '0));

  // R9: in falling-only mode a new event needs a high-to-low step
  a_r9_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & $past(sense) & ~$past(hist_lvl & ~sync_lvl)) == '0));
endmodule

// File: rtl/gpio_ec_regs.sv
module gpio_ec_regs
  import gpio_ec_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [W/8-1:0]   bus_be,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [W-1:0]     sync_lvl,
  input  logic [W-1:0]     evt_q,
  output logic [W-1:0]     dirn_q,
  output logic [W-1:0]     sense_q,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     level_q,
  output logic             evt_clr_en,
  output logic [W-1:0]     evt_clr_bits
);
  localparam logic [W/8-1:0] FULL = '1;

  logic [W-1:0] open_q;
  logic         full, wr_ok;
  logic         dirn_en, open_en, level_en, mask_en, sense_en;
  logic [W-1:0] level_d;

  assign full     = (bus_be == FULL);
  assign wr_ok    = bus_wr && full;
  assign dirn_en  = wr_ok && (bus_addr == OFS_DIRN);
  assign open_en  = wr_ok && (bus_addr == OFS_OPEN);
  assign level_en = wr_ok && (bus_addr == OFS_LEVEL);
  assign mask_en  = wr_ok && (bus_addr == OFS_MASK);
  assign sense_en = wr_ok && (bus_addr == OFS_SENSE);

  assign evt_clr_en   = wr_ok && (bus_addr == OFS_EVENT);
  assign evt_clr_bits = bus_wdata;

  // output bits keep or take the written value, input bits follow the pad
  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (dirn_q[i]) level_d[i] = level_en ? bus_wdata[i] : level_q[i];
      else           level_d[i] = sync_lvl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirn_q  <= '0;
      open_q  <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      level_q <= '0;
    end else begin
      if (dirn_en)  dirn_q  <= bus_wdata;
      if (open_en)  open_q  <= bus_wdata;
      if (mask_en)  mask_q  <= bus_wdata;
      if (sense_en) sense_q <= bus_wdata;
      level_q <= level_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && full) begin
      unique case (bus_addr)
        OFS_DIRN:  bus_rdata = dirn_q;
        OFS_OPEN:  bus_rdata = open_q;
        OFS_LEVEL: bus_rdata = level_q;
        OFS_EVENT: bus_rdata = evt_q;
        OFS_MASK:  bus_rdata = mask_q;
        OFS_SENSE: bus_rdata = sense_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R3: a partial write changes no stored setting
  a_r3_partial_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !full) |=> ($stable(dirn_q) && $stable(open_q) && $stable(mask_q) && $stable(sense_q)));

  // R3: a partial read returns zero
  a_r3_partial_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !full) |-> (bus_rdata == '0));

  // R6: a level write lands on output bits only
  a_r6_level_write_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    level_en |=> ((level_q & dirn_q) == ($past(bus_wdata) & dirn_q)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ec_pkg::*;
#(
  parameter int PINS       = WORD_W,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [PINS/8-1:0] bus_be,
  input  logic [PINS-1:0]  bus_wdata,
  output logic [PINS-1:0]  bus_rdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_oe,
  output logic             irq
);
  localparam int TOP = PINS - 1;

  logic [PINS-1:0] pad_r, sync_lvl, hist_lvl;
  logic [PINS-1:0] dirn_q, sense_q, mask_q, level_q, evt_q;
  logic            evt_clr_en;
  logic [PINS-1:0] evt_clr_bits;

  // pin n sits at register bit TOP-n
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    assign pad_r[TOP-n] = pin_in[n];
    assign pin_oe[n]    = dirn_q[TOP-n];
    assign pin_out[n]   = dirn_q[TOP-n] & level_q[TOP-n];
  end

  gpio_ec_sync #(.W(PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_r),
    .sync_lvl(sync_lvl), .hist_lvl(hist_lvl)
  );

  gpio_ec_regs #(.W(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_lvl(sync_lvl), .evt_q(evt_q),
    .dirn_q(dirn_q), .sense_q(sense_q), .mask_q(mask_q), .level_q(level_q),
    .evt_clr_en(evt_clr_en), .evt_clr_bits(evt_clr_bits)
  );

  gpio_ec_event #(.W(PINS)) u_event (
    .clk(clk), .rst_n(rst_n),
    .sync_lvl(sync_lvl), .hist_lvl(hist_lvl),
    .dirn(dirn_q), .sense(sense_q),
    .clr_en(evt_clr_en), .clr_bits(evt_clr_bits),
    .evt_q(evt_q)
  );

  assign irq = |(evt_q & mask_q);

  // R10: writing an all-zero mask drops the interrupt on the next cycle
  a_r10_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be == '1 && bus_addr == OFS_MASK && bus_wdata == '0) |=> !irq);

  // R5: an input pin is never driven
  a_r5_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag,
                    input logic [3:0] be = 4'hF);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic at_neg_chk(input string tag, input logic [31:0] act_dummy_unused, input logic [31:0] exp);
    @(negedge clk);
    chk(tag, act_dummy_unused, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_be = 4'hF;
    bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pin_oe", pin_oe, 32'd0);
    chk("R1 pin_out", pin_out, 32'd0);
    rd(12'h000, 32'h0, "R1 dirn");
    rd(12'h004, 32'h0, "R1 open");
    rd(12'h008, 32'h0, "R1 level");
    rd(12'h00C, 32'h0, "R1 event");
    rd(12'h010, 32'h0, "R1 mask");
    rd(12'h014, 32'h0, "R1 sense");

    // R2 readback
    wr(12'h000, 32'hF000_0000);
    wr(12'h004, 32'h1234_5678);
    wr(12'h010, 32'h0000_FF00);
    wr(12'h014, 32'h0000_00F0);
    rd(12'h000, 32'hF000_0000, "R2 dirn");
    rd(12'h004, 32'h1234_5678, "R2 open");
    rd(12'h010, 32'h0000_FF00, "R2 mask");
    rd(12'h014, 32'h0000_00F0, "R2 sense");
    wr(12'h010, 32'h0);
    wr(12'h014, 32'h0);

    // R5 pin mapping: pins 0..3 outputs, bits 31 and 29 high -> pins 0 and 2
    wr(12'h008, 32'hA000_0000);
    @(negedge clk);
    chk("R5 pin_out", pin_out, 32'h0000_0005);
    chk("R5 pin_oe", pin_oe, 32'h0000_000F);
    rd(12'h008, 32'hA000_0000, "R5 level");

    // R3 partial accesses
    wr(12'h000, 32'h0, 4'h3);
    rd(12'h000, 32'hF000_0000, "R3 partial write");
    rd(12'h004, 32'h0, "R3 partial read", 4'hC);

    // R4 unmapped offsets
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h018, 32'h0, "R4 unmapped read");
    rd(12'h000, 32'hF000_0000, "R4 dirn kept");
    rd(12'h010, 32'h0, "R4 mask kept");

    // R6 input follows pad; level write spares inputs
    @(posedge clk); #1; pin_in[31] = 1'b1;
    settle();
    rd(12'h008, 32'hA000_0001, "R6 input level");
    wr(12'h008, 32'h5000_0000);
    rd(12'h008, 32'h5000_0001, "R6 write spares input");
    @(negedge clk);
    chk("R6 pin_out", pin_out, 32'h0000_000A);

    // R8 rising edge in any-change mode
    rd(12'h00C, 32'h0000_0001, "R8 rise event");

    // R7 write-one-to-clear
    wr(12'h00C, 32'hFFFF_FFFE);
    rd(12'h00C, 32'h0000_0001, "R7 zero bits kept");
    wr(12'h00C, 32'h0000_0001);
    rd(12'h00C, 32'h0, "R7 cleared");

    // R8 falling edge in any-change mode
    @(posedge clk); #1; pin_in[31] = 1'b0;
    settle();
    rd(12'h00C, 32'h0000_0001, "R8 fall event");
    wr(12'h00C, 32'h0000_0001);

    // R9 falling-only mode
    wr(12'h014, 32'h0000_0001);
    @(posedge clk); #1; pin_in[31] = 1'b1;
    settle();
    rd(12'h00C, 32'h0, "R9 rise ignored");
    @(posedge clk); #1; pin_in[31] = 1'b0;
    settle();
    rd(12'h00C, 32'h0000_0001, "R9 fall event");

    // R10 interrupt from event and mask
    @(negedge clk);
    chk("R10 masked off", {31'd0, irq}, 32'd0);
    wr(12'h010, 32'h0000_0001);
    @(negedge clk);
    chk("R10 unmasked", {31'd0, irq}, 32'd1);
    wr(12'h010, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R10 other bits", {31'd0, irq}, 32'd0);
    wr(12'h010, 32'h0000_0001);
    wr(12'h00C, 32'h0000_0001);
    @(negedge clk);
    chk("R10 after clear", {31'd0, irq}, 32'd0);

    // R11 edge and clear in the same cycle
    wr(12'h014, 32'h0);
    @(posedge clk); #1; pin_in[31] = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    bus_addr = 12'h00C; bus_wdata = 32'h1; bus_be = 4'hF; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    rd(12'h00C, 32'h0000_0001, "R11 set wins");
    @(negedge clk);
    chk("R11 irq", {31'd0, irq}, 32'd1);
    wr(12'h00C, 32'h0000_0001);

    // R12 pads of output pins are ignored
    @(posedge clk); #1; pin_in[0] = 1'b1;
    settle();
    rd(12'h00C, 32'h0, "R12 no event");
    rd(12'h008, 32'h5000_0001, "R12 level kept");
    wr(12'h008, 32'hD000_0000);
    settle();
    rd(12'h00C, 32'h0, "R12 output toggle no event");
    rd(12'h008, 32'hD000_0001, "R12 level written");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule